// File: doc/BRIEF.md
# Signed multiply-accumulate unit with read-and-clear

The block keeps a 64-bit signed accumulator. On an operation strobe it adds or subtracts the full signed product of two 32-bit operands. Each operation takes one clock edge, so the next operation can be issued in the following cycle and sees the updated total.

A read-and-clear operation returns the accumulator shifted right by 28 bits, which is bits 59:28, as a registered 32-bit result with a one-cycle valid pulse. On the same edge it zeroes the whole accumulator. The accumulator also appears as two 32-bit registers, a low half and a high half. Software can write either half and read it back without a wait through a small register port.

The block is meant to sit next to an integer pipeline as the fixed-point dot-product engine. Sums wrap modulo 2^64. There is no saturation and no overflow flag.

Top module: `mac_unit`

## Requirements
- R1: The register port selects the low half (bits 31:0) with `reg_addr_i`=0 and the high half (bits 63:32) with `reg_addr_i`=1. `reg_rdata_o` shows the selected half of the current accumulator combinationally.
- R2: Op code 00 with `op_valid_i` adds the signed 64-bit product of `op_a_i` and `op_b_i` to the accumulator on that clock edge. An operation in the next cycle sees the new value.
- R3: Op code 01 with `op_valid_i` subtracts the signed 64-bit product from the accumulator on that clock edge.
- R4: Op code 10 with `op_valid_i` loads accumulator bits 59:28 into `result_o` and zeroes all 64 accumulator bits, both on the same edge.
- R5: `result_valid_o` is high for exactly the one cycle after each read-and-clear edge and is low at all other times. `result_o` holds its last value until the next read-and-clear.
- R6: A register write with no operation replaces only the addressed half. The other half keeps its value.
- R7: Accumulation wraps modulo 2^64 in both directions.
- R8: When a valid operation with code 00, 01 or 10 and a register write occur in the same cycle, the operation takes effect and the write is dropped.
- R9: Op code 11 is reserved. It leaves the accumulator, `result_o` and `result_valid_o` unchanged.
- R10: Reset clears the accumulator, `result_o` and `result_valid_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | Operation strobe |
| op_code_i | input | 2 | 00 accumulate, 01 subtract, 10 read-and-clear, 11 reserved |
| op_a_i | input | 32 | Signed operand A |
| op_b_i | input | 32 | Signed operand B |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | Half select: 0 low, 1 high |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Selected accumulator half |
| result_o | output | 32 | Read-and-clear result |
| result_valid_o | output | 1 | Result valid pulse |

## Verification
The assertions check on every cycle the following:
- the one-edge update for accumulate and subtract, measured against the separately computed product;
- the zeroing and the result slice of read-and-clear;
- the shape of the valid pulse;
- the hold of the accumulator when the unit is idle;
- half-isolated writes.

The scenarios in the bench show the rest:
- the arithmetic across a sweep of extreme operand pairs;
- wraparound at both ends of the 64-bit range;
- the dropped write when a write collides with an operation;
- the reserved code;
- back-to-back issue.

// File: rtl/mac_pkg.sv
package mac_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ACC_W  = 2 * DATA_W;
  localparam int unsigned SLICE_SHIFT = 28;

  typedef enum logic [1:0] {
    OP_MAC  = 2'b00,
    OP_MSB  = 2'b01,
    OP_RDCL = 2'b10,
    OP_RSVD = 2'b11
  } mac_op_e;
endpackage

// File: rtl/mac_mult.sv
module mac_mult #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic [2*W-1:0] prod_o
);
  logic signed [2*W-1:0] a_ext, b_ext;
  always_comb begin
    a_ext  = {{W{a_i[W-1]}}, a_i};
    b_ext  = {{W{b_i[W-1]}}, b_i};
    prod_o = a_ext * b_ext;
  end
endmodule

// File: rtl/mac_acc.sv
module mac_acc
  import mac_pkg::*;
#(
  parameter int unsigned W = 32,
  localparam int unsigned AW = 2 * W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          op_valid_i,
  input  mac_op_e       op_code_i,
  input  logic [AW-1:0] prod_i,
  input  logic          reg_we_i,
  input  logic          reg_addr_i,
  input  logic [W-1:0]  reg_wdata_i,
  output logic [AW-1:0] acc_o
);
  logic [AW-1:0] acc_q, acc_d;
  logic          op_act;
  logic [1:0]    half_we;

  assign op_act = op_valid_i && (op_code_i != OP_RSVD);

  // operations take priority; writes only land on idle cycles
  for (genvar h = 0; h < 2; h++) begin : g_half_we
    assign half_we[h] = reg_we_i && !op_act && (reg_addr_i == h[0]);
  end

  always_comb begin
    acc_d = acc_q;
    if (op_act) begin
      unique case (op_code_i)
        OP_MAC:  acc_d = acc_q + prod_i;
        OP_MSB:  acc_d = acc_q - prod_i;
        OP_RDCL: acc_d = '0;
        default: acc_d = acc_q;
      endcase
    end else begin
      if (half_we[0]) acc_d[W-1:0]  = reg_wdata_i;
      if (half_we[1]) acc_d[AW-1:W] = reg_wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '0;
    else         acc_q <= acc_d;
  end

  assign acc_o = acc_q;

  assert_mac_add_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_code_i == OP_MAC) |=> acc_q == AW'($past(acc_q) + $past(prod_i)));
  assert_msb_sub_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_code_i == OP_MSB) |=> acc_q == AW'($past(acc_q) - $past(prod_i)));
  assert_rdcl_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_code_i == OP_RDCL) |=> acc_q == '0);
  assert_write_lo_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && !reg_addr_i && !(op_valid_i && op_code_i != OP_RSVD))
      |=> acc_q[W-1:0] == $past(reg_wdata_i) && $stable(acc_q[AW-1:W]));
  assert_write_hi_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i && !(op_valid_i && op_code_i != OP_RSVD))
      |=> acc_q[AW-1:W] == $past(reg_wdata_i) && $stable(acc_q[W-1:0]));
  assert_idle_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!reg_we_i && !(op_valid_i && op_code_i != OP_RSVD)) |=> $stable(acc_q));
endmodule

// File: rtl/mac_rdout.sv
module mac_rdout #(
  parameter int unsigned W = 32,
  parameter int unsigned SHIFT = 28,
  localparam int unsigned AW = 2 * W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fire_i,
  input  logic [AW-1:0] acc_i,
  output logic [W-1:0]  result_o,
  output logic          valid_o
);
  logic [W-1:0] res_q;
  logic         vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= fire_i;
      if (fire_i) res_q <= acc_i[SHIFT +: W];
    end
  end

  assign result_o = res_q;
  assign valid_o  = vld_q;

  assert_valid_rise_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i |=> valid_o);
  assert_valid_low_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fire_i |=> !valid_o);
  assert_result_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fire_i |=> $stable(result_o));
endmodule

// File: rtl/mac_unit.sv
module mac_unit
  import mac_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              op_valid_i,
  input  logic [1:0]        op_code_i,
  input  logic [DATA_W-1:0] op_a_i,
  input  logic [DATA_W-1:0] op_b_i,
  input  logic              reg_we_i,
  input  logic              reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic [DATA_W-1:0] result_o,
  output logic              result_valid_o
);
  logic [ACC_W-1:0] prod, acc;
  mac_op_e          op;
  logic             rdcl_fire;

  assign op        = mac_op_e'(op_code_i);
  assign rdcl_fire = op_valid_i && (op == OP_RDCL);

  mac_mult #(.W(DATA_W)) u_mult (
    .a_i(op_a_i), .b_i(op_b_i), .prod_o(prod)
  );

  mac_acc #(.W(DATA_W)) u_acc (
    .clk_i(clk_i), .rst_ni(rst_ni), .op_valid_i(op_valid_i), .op_code_i(op),
    .prod_i(prod), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .acc_o(acc)
  );

  mac_rdout #(.W(DATA_W), .SHIFT(SLICE_SHIFT)) u_rdout (
    .clk_i(clk_i), .rst_ni(rst_ni), .fire_i(rdcl_fire), .acc_i(acc),
    .result_o(result_o), .valid_o(result_valid_o)
  );

  assign reg_rdata_o = reg_addr_i ? acc[ACC_W-1:DATA_W] : acc[DATA_W-1:0];

  assert_rdcl_slice_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdcl_fire |=> result_o == $past(acc[SLICE_SHIFT +: DATA_W]));
  assert_collide_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && op_valid_i && op_code_i == 2'b00)
      |=> acc == ACC_W'($past(acc) + $past(prod)));
endmodule

// File: tb/mac_unit_bench.sv
`timescale 1ns/1ps
module mac_unit_bench;
  logic clk = 0, rst_n = 0;
  logic op_valid = 0, reg_we = 0, reg_addr = 0;
  logic [1:0] op_code = 0;
  logic [31:0] op_a = 0, op_b = 0, reg_wdata = 0;
  logic [31:0] reg_rdata, result;
  logic result_valid;
  int n_vec = 0, n_bad = 0;
  logic [63:0] model;
  logic [31:0] exp_res;

  always #2 clk = ~clk;

  mac_unit u_mac_unit (
    .clk_i(clk), .rst_ni(rst_n), .op_valid_i(op_valid), .op_code_i(op_code),
    .op_a_i(op_a), .op_b_i(op_b), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .result_o(result),
    .result_valid_o(result_valid)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // call right after a negedge; reads both halves within the low phase
  task automatic read_acc(output logic [63:0] v);
    reg_addr = 0; #0.5; v[31:0] = reg_rdata;
    reg_addr = 1; #0.5; v[63:32] = reg_rdata;
  endtask

  task automatic issue(logic [1:0] code, logic [31:0] a, logic [31:0] b);
    @(negedge clk);
    op_valid = 1; op_code = code; op_a = a; op_b = b;
    @(negedge clk);
    op_valid = 0;
  endtask

  task automatic wr(logic addr, logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = addr; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  function automatic logic [63:0] sprod(logic [31:0] a, logic [31:0] b);
    longint x = longint'(signed'(a)) * longint'(signed'(b));
    return x;
  endfunction

  logic [31:0] pat [8] = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h7FFF_FFFF,
                           32'h8000_0000, 32'h3, 32'hFFFF_FFFB, 32'h1234_5678};

  initial begin
    #(200000 * 4);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [63:0] v;
    repeat (3) @(negedge clk);
    read_acc(v);
    check("R10 acc", v, 0);
    check("R10 result", {32'h0, result}, 0);
    check("R10 valid", {63'h0, result_valid}, 0);
    rst_n = 1;
    model = 0;

    // R2/R1/R7 sweep of accumulate
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++) begin
        issue(2'b00, pat[i], pat[j]);
        model = model + sprod(pat[i], pat[j]);
        read_acc(v);
        check("R2 mac", v, model);
      end
    // R3 sweep of subtract
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j += 3) begin
        issue(2'b01, pat[i], pat[j]);
        model = model - sprod(pat[i], pat[j]);
        read_acc(v);
        check("R3 msb", v, model);
      end

    // R4/R5 read-and-clear
    exp_res = model[59:28];
    issue(2'b10, 0, 0);
    check("R5 valid pulse", {63'h0, result_valid}, 1);
    check("R4 slice", {32'h0, result}, {32'h0, exp_res});
    read_acc(v);
    check("R4 cleared", v, 0);
    model = 0;
    @(negedge clk);
    check("R5 valid drop", {63'h0, result_valid}, 0);
    check("R5 result hold", {32'h0, result}, {32'h0, exp_res});

    // R6 half writes
    wr(0, 32'hA5A5_0001);
    read_acc(v);
    check("R6 low write", v, 64'h0000_0000_A5A5_0001);
    wr(1, 32'hC3C3_0002);
    read_acc(v);
    check("R6 high write", v, 64'hC3C3_0002_A5A5_0001);
    check("R1 high read", {32'h0, reg_rdata}, 64'hC3C3_0002);
    model = 64'hC3C3_0002_A5A5_0001;

    // R4 slice of a known pattern
    exp_res = model[59:28];
    issue(2'b10, 0, 0);
    check("R4 known slice", {32'h0, result}, {32'h0, exp_res});
    model = 0;

    // R7 wrap upward and downward
    wr(0, 32'hFFFF_FFFF); wr(1, 32'h7FFF_FFFF);
    issue(2'b00, 1, 1);
    read_acc(v);
    check("R7 wrap pos", v, 64'h8000_0000_0000_0000);
    wr(0, 32'hFFFF_FFFF); wr(1, 32'hFFFF_FFFF);
    issue(2'b00, 1, 1);
    read_acc(v);
    check("R7 wrap zero", v, 0);
    issue(2'b01, 1, 1);
    read_acc(v);
    check("R7 wrap neg", v, 64'hFFFF_FFFF_FFFF_FFFF);

    // R8 collision: op wins, write dropped
    wr(0, 32'h10); wr(1, 0);
    @(negedge clk);
    op_valid = 1; op_code = 2'b00; op_a = 5; op_b = 7;
    reg_we = 1; reg_addr = 0; reg_wdata = 32'hDEAD_BEEF;
    @(negedge clk);
    op_valid = 0; reg_we = 0;
    read_acc(v);
    check("R8 collide mac", v, 64'h10 + 35);
    @(negedge clk);
    op_valid = 1; op_code = 2'b10;
    reg_we = 1; reg_addr = 1; reg_wdata = 32'hDEAD_BEEF;
    @(negedge clk);
    op_valid = 0; reg_we = 0;
    read_acc(v);
    check("R8 collide rdcl", v, 0);

    // R9 reserved code
    wr(0, 32'h4000_0000); wr(1, 32'h2);
    exp_res = result;
    issue(2'b11, 32'h7FFF_FFFF, 32'h7FFF_FFFF);
    read_acc(v);
    check("R9 acc kept", v, 64'h0000_0002_4000_0000);
    check("R9 no valid", {63'h0, result_valid}, 0);
    check("R9 result kept", {32'h0, result}, {32'h0, exp_res});

    // R2 back-to-back: mac then read-and-clear in consecutive cycles
    model = 64'h0000_0002_4000_0000 + sprod(32'h1000, 32'h3000);
    @(negedge clk);
    op_valid = 1; op_code = 2'b00; op_a = 32'h1000; op_b = 32'h3000;
    @(negedge clk);
    op_code = 2'b10;
    @(negedge clk);
    op_valid = 0;
    check("R2 back-to-back", {32'h0, result}, {32'h0, model[59:28]});
    check("R5 b2b valid", {63'h0, result_valid}, 1);
    read_acc(v);
    check("R4 b2b clear", v, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule